// File: doc/BRIEF.md
# PWM Duty Cycle Meter

This block watches one pulse-width-modulated input, sampled on the system clock, and measures each modulation period in clock ticks. It splits each period into its high part and its low part. A control input picks the input edge that opens a period: rising or falling. When a period closes, the block delivers three results under a one-clock valid strobe: the period length, the high share as a truncated whole-number percentage, and the high share as an 8-bit fraction of 256. It also keeps a count of the periods it has reported. The input passes through a two-flop synchroniser before any edge is detected. Interval counters saturate rather than wrap, and a sticky flag records that saturation happened.

Two state machines run the block. The interval timer has two states. It leaves `T_UNARMED` for `T_ARMED` on the first period-start edge after reset, and it stays in `T_ARMED` until reset. While armed, every period-start edge closes a period. The duty divider is a restoring divider that produces one quotient bit per clock. It moves `D_IDLE` → `D_PCT` when a closed period arrives, `D_PCT` → `D_FRAC` after nine quotient bits, `D_FRAC` → `D_DONE` after nine more, and `D_DONE` → `D_IDLE` on the next clock. The strobe is high only in `D_DONE`. A period that closes while the divider is not in `D_IDLE` is not reported, so the input period must be longer than the divider's roughly two-dozen-clock latency.

Top module: `pwm_duty_meter`

## Requirements
- R1: After reset, `res_valid` is 0, `cycle_count` is 0 and `overflow` is 0.
- R2: With `start_on_fall` = 0, a period opens at a rising edge of `pwm_in`. The high time is the number of clocks from that rising edge to the next falling edge. The low time runs from that falling edge to the next rising edge, which closes the period and produces its result.
- R3: With `start_on_fall` = 1, a period closes at each falling edge. Its result uses the high time that ends at that falling edge and the low time that came just before it.
- R4: The first period-start edge after reset only arms the block and produces no result. The partial interval before it is never reported.
- R5: `res_pct` equals floor(100 × high / (high + low)).
- R6: `res_frac` equals floor(256 × high / (high + low)), clamped to 255.
- R7: `res_period` equals high + low for the same period. It is presented together with `res_pct` and `res_frac` while `res_valid` is high, and `res_valid` is never high on two consecutive clocks.
- R8: `cycle_count` increases by one on the clock edge that ends each `res_valid` pulse and does not change at any other time.
- R9: An interval counter stops at 2^TICK_W − 1, and an interval that reached that count is reported as that value. `overflow` goes to 1 when such an interval is latched and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | 1 | Asynchronous PWM input |
| start_on_fall | input | 1 | 0: periods open on rising edges; 1: on falling edges |
| res_valid | output | 1 | One-clock strobe that qualifies the result outputs |
| res_period | output | TICK_W+1 | High plus low time, in clocks |
| res_pct | output | 7 | Truncated duty percentage, 0 to 100 |
| res_frac | output | 8 | Duty as a fraction of 256, clamped to 255 |
| cycle_count | output | COUNT_W | Number of periods reported since reset |
| overflow | output | 1 | Sticky flag: some interval saturated |

## Verification
Counter saturation is the hardest condition to reach from the ports. At the default width it needs a pulse longer than sixteen million clocks. The bench therefore builds the block with 8-bit interval counters and holds the input high for 300 clocks. It then checks that the reported period, percentage and fraction use the clamped high time of 255, and that the flag stays set through the period after. The start-up discard is checked in both edge modes by confirming that no strobe has appeared by the time the first full period has been driven.

// File: rtl/pwm_meter_pkg.sv
`timescale 1ns/1ps
package pwm_meter_pkg;

    // Interval timer: waits for the first period-start edge, then reports.
    typedef enum logic {
        T_UNARMED = 1'b0,
        T_ARMED   = 1'b1
    } tmr_state_e;

    // Duty divider: percentage quotient, then fraction quotient, then strobe.
    typedef enum logic [1:0] {
        D_IDLE = 2'd0,
        D_PCT  = 2'd1,
        D_FRAC = 2'd2,
        D_DONE = 2'd3
    } div_state_e;

    // Both quotients are below 512, so nine quotient bits suffice.
    localparam int QUOT_W = 9;
    localparam int PCT_W  = 7;
    localparam int FRAC_W = 8;

endpackage

// File: rtl/pwm_edge_sync.sv
`timescale 1ns/1ps
module pwm_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise,
    output logic fall
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        rise = sync_q & ~prev_q;
        fall = ~sync_q & prev_q;
    end

    // R2: edges of the two kinds alternate and never coincide
    a_r2_single_edge: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rise, fall}));

    a_r2_no_double_rise: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/pwm_interval_timer.sv
`timescale 1ns/1ps
module pwm_interval_timer
    import pwm_meter_pkg::*;
#(
    parameter int TICK_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              fall,
    input  logic              start_on_fall,
    output logic              cyc_done,
    output logic [TICK_W-1:0] high_t,
    output logic [TICK_W-1:0] low_t,
    output logic              ovf
);

    localparam logic [TICK_W-1:0] TICK_MAX = '1;

    tmr_state_e        state_q;
    tmr_state_e        state_d;
    logic [TICK_W-1:0] cnt_q;
    logic              start_edge;
    logic              any_edge;
    logic              done_q;

    always_comb begin
        start_edge = start_on_fall ? fall : rise;
        any_edge   = rise | fall;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_UNARMED: if (start_edge) state_d = T_ARMED;
            T_ARMED:   state_d = T_ARMED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= T_UNARMED;
        else     state_q <= state_d;
    end

    // Tick counter: restarts at 1 on every edge, holds at its maximum
    always_ff @(posedge clk) begin
        if (rst)                  cnt_q <= '0;
        else if (any_edge)        cnt_q <= TICK_W'(1);
        else if (cnt_q != TICK_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // Interval latches and sticky saturation flag
    always_ff @(posedge clk) begin
        if (rst) begin
            high_t <= TICK_W'(1);
            low_t  <= TICK_W'(1);
            ovf    <= 1'b0;
        end else begin
            if (rise) low_t  <= cnt_q;
            if (fall) high_t <= cnt_q;
            if (any_edge && (cnt_q == TICK_MAX)) ovf <= 1'b1;
        end
    end

    // Output process: a closed period is announced only in the armed state
    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= (state_q == T_ARMED) && start_edge;
    end

    always_comb cyc_done = done_q;

    // R9: counter holds at its ceiling until an edge restarts it
    a_r9_cnt_saturates: assert property (@(posedge clk) disable iff (rst)
        (!any_edge && cnt_q == TICK_MAX) |=> (cnt_q == TICK_MAX));

    // R9: flag is sticky
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R4: nothing is announced before arming
    a_r4_no_done_unarmed: assert property (@(posedge clk) disable iff (rst)
        (state_q == T_UNARMED) |=> !cyc_done);

    // R2: latched intervals are never zero once a period is announced
    a_r2_intervals_nonzero: assert property (@(posedge clk) disable iff (rst)
        cyc_done |-> (high_t != '0 && low_t != '0));

endmodule

// File: rtl/pwm_duty_divider.sv
`timescale 1ns/1ps
module pwm_duty_divider
    import pwm_meter_pkg::*;
#(
    parameter int TICK_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TICK_W-1:0] high_t,
    input  logic [TICK_W-1:0] low_t,
    output logic              done,
    output logic [TICK_W:0]   period,
    output logic [PCT_W-1:0]  pct,
    output logic [FRAC_W-1:0] frac
);

    localparam int PER_W  = TICK_W + 1;
    localparam int DVD_W  = PER_W + QUOT_W;
    localparam int STEP_W = $clog2(QUOT_W);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(QUOT_W - 1);

    div_state_e         state_q;
    div_state_e         state_d;
    logic [PER_W-1:0]   divisor_q;
    logic [PER_W-1:0]   rem_q;
    logic [QUOT_W-1:0]  shf_q;
    logic [QUOT_W-1:0]  quo_q;
    logic [STEP_W-1:0]  step_q;
    logic [TICK_W-1:0]  high_hold_q;
    logic [PCT_W-1:0]   pct_q;
    logic [FRAC_W-1:0]  frac_q;
    logic [PER_W-1:0]   period_q;

    logic [PER_W:0]     trial;
    logic [PER_W:0]     diff;
    logic               take;
    logic [PER_W-1:0]   rem_nx;
    logic [QUOT_W-1:0]  quo_nx;
    logic               last_step;
    logic [DVD_W-1:0]   dvd_pct;
    logic [DVD_W-1:0]   dvd_frac;

    // One restoring step: shift in the next dividend bit, subtract if it fits
    always_comb begin
        trial     = {rem_q, shf_q[QUOT_W-1]};
        take      = (trial >= {1'b0, divisor_q});
        diff      = trial - {1'b0, divisor_q};
        rem_nx    = take ? diff[PER_W-1:0] : trial[PER_W-1:0];
        quo_nx    = {quo_q[QUOT_W-2:0], take};
        last_step = (step_q == LAST_STEP);
        dvd_pct   = DVD_W'(high_t) * DVD_W'(100);
        dvd_frac  = DVD_W'(high_hold_q) << FRAC_W;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            D_IDLE: if (start)     state_d = D_PCT;
            D_PCT:  if (last_step) state_d = D_FRAC;
            D_FRAC: if (last_step) state_d = D_DONE;
            D_DONE: state_d = D_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= D_IDLE;
        else     state_q <= state_d;
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            divisor_q   <= '0;
            rem_q       <= '0;
            shf_q       <= '0;
            quo_q       <= '0;
            step_q      <= '0;
            high_hold_q <= '0;
            pct_q       <= '0;
            frac_q      <= '0;
            period_q    <= '0;
        end else begin
            unique case (state_q)
                D_IDLE: begin
                    if (start) begin
                        high_hold_q <= high_t;
                        divisor_q   <= PER_W'(high_t) + PER_W'(low_t);
                        rem_q       <= dvd_pct[DVD_W-1:QUOT_W];
                        shf_q       <= dvd_pct[QUOT_W-1:0];
                        quo_q       <= '0;
                        step_q      <= '0;
                    end
                end
                D_PCT: begin
                    if (last_step) begin
                        pct_q  <= quo_nx[PCT_W-1:0];
                        rem_q  <= dvd_frac[DVD_W-1:QUOT_W];
                        shf_q  <= dvd_frac[QUOT_W-1:0];
                        quo_q  <= '0;
                        step_q <= '0;
                    end else begin
                        rem_q  <= rem_nx;
                        shf_q  <= {shf_q[QUOT_W-2:0], 1'b0};
                        quo_q  <= quo_nx;
                        step_q <= step_q + 1'b1;
                    end
                end
                D_FRAC: begin
                    if (last_step) begin
                        frac_q   <= quo_nx[QUOT_W-1] ? '1 : quo_nx[FRAC_W-1:0];
                        period_q <= divisor_q;
                        step_q   <= '0;
                    end else begin
                        rem_q  <= rem_nx;
                        shf_q  <= {shf_q[QUOT_W-2:0], 1'b0};
                        quo_q  <= quo_nx;
                        step_q <= step_q + 1'b1;
                    end
                end
                D_DONE: begin
                end
            endcase
        end
    end

    // Output process
    always_comb begin
        done   = (state_q == D_DONE);
        period = period_q;
        pct    = pct_q;
        frac   = frac_q;
    end

    // R5: percentage never exceeds 100
    a_r5_pct_bound: assert property (@(posedge clk) disable iff (rst)
        done |-> (pct <= PCT_W'(100)));

    // R6: the 256-scaled fraction is never below the 100-scaled percentage
    a_r6_frac_ge_pct: assert property (@(posedge clk) disable iff (rst)
        done |-> ({1'b0, frac} >= {2'b00, pct}));

    // R7: strobe lasts exactly one clock
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: both intervals are at least one clock, so the period is at least two
    a_r7_period_min: assert property (@(posedge clk) disable iff (rst)
        done |-> (period >= PER_W'(2)));

endmodule

// File: rtl/pwm_duty_meter.sv
`timescale 1ns/1ps
module pwm_duty_meter
    import pwm_meter_pkg::*;
#(
    parameter int TICK_W  = 24,
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwm_in,
    input  logic               start_on_fall,
    output logic               res_valid,
    output logic [TICK_W:0]    res_period,
    output logic [PCT_W-1:0]   res_pct,
    output logic [FRAC_W-1:0]  res_frac,
    output logic [COUNT_W-1:0] cycle_count,
    output logic               overflow
);

    logic              rise;
    logic              fall;
    logic              cyc_done;
    logic [TICK_W-1:0] high_t;
    logic [TICK_W-1:0] low_t;
    logic [COUNT_W-1:0] count_q;

    pwm_edge_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pwm_in),
        .rise     (rise),
        .fall     (fall)
    );

    pwm_interval_timer #(.TICK_W(TICK_W)) u_timer (
        .clk           (clk),
        .rst           (rst),
        .rise          (rise),
        .fall          (fall),
        .start_on_fall (start_on_fall),
        .cyc_done      (cyc_done),
        .high_t        (high_t),
        .low_t         (low_t),
        .ovf           (overflow)
    );

    pwm_duty_divider #(.TICK_W(TICK_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .start  (cyc_done),
        .high_t (high_t),
        .low_t  (low_t),
        .done   (res_valid),
        .period (res_period),
        .pct    (res_pct),
        .frac   (res_frac)
    );

    always_ff @(posedge clk) begin
        if (rst)            count_q <= '0;
        else if (res_valid) count_q <= count_q + 1'b1;
    end

    always_comb cycle_count = count_q;

    // R8: the count moves only across a strobe
    a_r8_count_holds: assert property (@(posedge clk) disable iff (rst)
        !res_valid |=> $stable(cycle_count));

endmodule

// File: tb/pwm_duty_meter_bench.sv
`timescale 1ns/1ps
module pwm_duty_meter_bench;

    localparam int TW = 8;
    localparam int CW = 8;
    localparam int TMAX = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwm_in = 1'b0;
    logic          start_on_fall = 1'b0;
    logic          res_valid;
    logic [TW:0]   res_period;
    logic [6:0]    res_pct;
    logic [7:0]    res_frac;
    logic [CW-1:0] cycle_count;
    logic          overflow;

    pwm_duty_meter #(.TICK_W(TW), .COUNT_W(CW)) u_pwm_duty_meter (
        .clk           (clk),
        .rst           (rst),
        .pwm_in        (pwm_in),
        .start_on_fall (start_on_fall),
        .res_valid     (res_valid),
        .res_period    (res_period),
        .res_pct       (res_pct),
        .res_frac      (res_frac),
        .cycle_count   (cycle_count),
        .overflow      (overflow)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int eh [0:127];
    int el [0:127];
    int wr = 0;
    int rd = 0;
    int n_valid = 0;
    int exp_cnt = 0;
    bit cnt_pending = 0;
    bit prev_valid = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int h, input int l);
        eh[wr] = (h > TMAX) ? TMAX : h;
        el[wr] = (l > TMAX) ? TMAX : l;
        wr++;
    endtask

    // Hold pwm_in at v for n clock edges, returning just after the last edge.
    task automatic hold(input bit v, input int n);
        pwm_in = v;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input bit mode);
        rst = 1'b1;
        pwm_in = 1'b0;
        start_on_fall = mode;
        repeat (4) @(posedge clk);
        #1;
        wr = 0; rd = 0; n_valid = 0; cnt_pending = 0; prev_valid = 0;
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(res_valid == 1'b0, "R1", "res_valid", int'(res_valid), 0);
        check(cycle_count == '0, "R1", "cycle_count", int'(cycle_count), 0);
        check(overflow == 1'b0, "R1", "overflow", int'(overflow), 0);
        @(posedge clk);
        #1;
    endtask

    // Result monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (cnt_pending) begin
                check(int'(cycle_count) == exp_cnt, "R8", "cycle_count",
                      int'(cycle_count), exp_cnt);
                cnt_pending = 0;
            end
            if (res_valid) begin
                int p;
                int ep;
                int ef;
                check(!prev_valid, "R7", "strobe width", 2, 1);
                n_valid++;
                if (rd < wr) begin
                    p  = eh[rd] + el[rd];
                    ep = (100 * eh[rd]) / p;
                    ef = (256 * eh[rd]) / p;
                    if (ef > 255) ef = 255;
                    check(int'(res_period) == p, "R7", "period", int'(res_period), p);
                    check(int'(res_pct) == ep, "R5", "pct", int'(res_pct), ep);
                    check(int'(res_frac) == ef, "R6", "frac", int'(res_frac), ef);
                    rd++;
                end else begin
                    check(1'b0, "R4", "unexpected result count", n_valid, wr);
                end
                exp_cnt = n_valid % (1 << CW);
                cnt_pending = 1;
            end
            prev_valid = res_valid;
        end
    end

    initial begin
        // Rising-edge periods: R2
        do_reset(1'b0);
        hold(1'b0, 10);
        for (int i = 1; i <= 44; i++) begin
            int h;
            int l;
            h = i;
            l = 45 - i + (i % 5);
            push(h, l);
            hold(1'b1, h);
            hold(1'b0, l);
            if (i == 1) check(n_valid == 0, "R4", "results after first period (rise)", n_valid, 0);
        end
        hold(1'b1, 40);
        hold(1'b0, 40);
        check(rd == wr, "R2", "results reported (rise mode)", rd, wr);
        check(overflow == 1'b0, "R9", "overflow without saturation", int'(overflow), 0);

        // Falling-edge periods: R3
        do_reset(1'b1);
        hold(1'b0, 10);
        hold(1'b1, 10);
        for (int i = 1; i <= 44; i++) begin
            int h;
            int l;
            h = 1 + ((i * 13) % 60);
            l = 30 + ((i * 7) % 23);
            push(h, l);
            hold(1'b0, l);
            hold(1'b1, h);
            if (i == 1) check(n_valid == 0, "R4", "results after first period (fall)", n_valid, 0);
        end
        hold(1'b0, 40);
        check(rd == wr, "R3", "results reported (fall mode)", rd, wr);

        // Saturation: R9
        do_reset(1'b0);
        hold(1'b0, 10);
        push(300, 10);
        hold(1'b1, 300);
        hold(1'b0, 10);
        check(overflow == 1'b1, "R9", "overflow after long pulse", int'(overflow), 1);
        push(20, 30);
        hold(1'b1, 20);
        hold(1'b0, 30);
        hold(1'b1, 40);
        hold(1'b0, 10);
        check(overflow == 1'b1, "R9", "overflow sticky", int'(overflow), 1);
        check(rd == wr, "R9", "results reported (saturation)", rd, wr);

        do_reset(1'b0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule